// File: doc/BRIEF.md
# Microcoded Serial Shift Sequencer

This block generates serial waveforms from a short program held in a 32-word instruction RAM. The program is built from three operations. A direct instruction sets the chip-select and clock pins. A shift instruction toggles the serial clock for a counted number of half periods, and on each bit it drives data from a 16-bit half register or samples data into it. A stop instruction sets the pins a final time and ends the run. A single-port register interface loads the program, preloads the two 16-bit halves of a 32-bit shift value, and sets the step-rate divider. It also starts a run at a chosen program counter.

Software starts a run and then waits for the interrupt. When the interrupt arrives, software reads the received bits from the two halves and reads the address of the stop instruction that ended the run. Different serial protocols (clock polarity, chip-select polarity, word lengths up to 32 bits split across two shifts) are made by loading different programs. The hardware does not change.

Top module: `sseq_top`

## Requirements
- R1: A word in the instruction RAM (register address bit 5 set, word index in address bits [4:0]) is written only while bit 0 of the memory-control register (address 1) is 1. Otherwise the word reads back unchanged.
- R2: A write to the control register (address 0) while idle stores the start counter from bits [5:0] and the early-sample flag from bit 11. If bit 15 is set, the write also starts a run, and busy (control bit 10) reads 1 from the next cycle. A control write during a run is ignored, and if it carries bit 15 it sets interrupt status bit 1.
- R3: During a run, one sequencer step happens every DIV+1 clocks, where DIV is the 8-bit value at address 5. The first step lands DIV+1 clocks after the start edge. The serial outputs change only on steps.
- R4: Instruction fields are: [31:28] opcode (1 direct, 2 shift, 3 stop, and any other value acts as stop), [27] 1 = drive out, 0 = sample in, [26] chip-select level, [25] clock idle level, [24] 1 = upper half (address 2), 0 = lower half (address 3), and [5:0] the half-period count N.
- R5: A direct instruction takes one step. It sets cs_o and sclk_o to its field levels and advances the program counter.
- R6: A shift instruction takes N+1 steps. On even-numbered steps (counting from 0) sclk_o is the inverse of the clock field. On odd-numbered steps sclk_o equals the clock field. cs_o follows the chip-select field.
- R7: In drive-out mode, each even step puts bit 15 of the selected half on sdo_o. Each odd step shifts that half left by one and fills the freed bit with 0, so bits leave MSB first.
- R8: In sample-in mode, sdi_i is shifted into bit 0 of the selected half. With the early flag at 1 the sample is taken on even steps. With the flag at 0 it is taken on odd steps.
- R9: A stop sets the pins from its fields and clears busy. It writes its own address to the stop register (address 4, bits [5:0]) and sets interrupt status bit 0.
- R10: irq_o is high when any status bit (address 6) has its enable bit (address 7) set. Writing 1 to a status bit clears it. A status bit that is set and cleared in the same cycle stays set.
- R11: Host writes to either half register during a run are ignored.
- R12: After reset every register and RAM word is 0, busy is 0, cs_o is 1, and sclk_o and sdo_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register or RAM word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| sdo_o | output | 1 | Serial data out |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases. A start that arrives during a run must not restart the program at a new address. A design that got this wrong would report the wrong stop address and lose the shifted data. With the early flag off, the sample must be taken on the odd half period. A design that sampled on the even one would capture the random input one half period early and return the wrong word. A drive-out shift must leave zeros behind in the operand, and a host write to a half register during a run must not corrupt it. The bench also runs an opcode value outside the three defined ones, which must stop the run rather than fall through to the next word. Finally, a status clear must leave the other status bit and irq_o consistent with its enable.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int INSTR_W = 32;
  localparam int CNT_W   = 6;

  localparam logic [3:0] OP_DIRECT = 4'h1;
  localparam logic [3:0] OP_SHIFT  = 4'h2;
  localparam logic [3:0] OP_STOP   = 4'h3;

  localparam int CTRL_START_BIT = 15;
  localparam int CTRL_EARLY_BIT = 11;
  localparam int CTRL_BUSY_BIT  = 10;

  typedef struct packed {
    logic [3:0]       op;
    logic             drive_out;
    logic             cs_lvl;
    logic             clk_lvl;
    logic             sel_hi;
    logic [17:0]      rsv;
    logic [CNT_W-1:0] half_cnt;
  } instr_t;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_MEM  = 3'd1,
    RG_HI   = 3'd2,
    RG_LO   = 3'd3,
    RG_STOP = 3'd4,
    RG_DIV  = 3'd5,
    RG_IST  = 3'd6,
    RG_IEN  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/sseq_iram.sv
module sseq_iram #(
  parameter  int DEPTH = 32,
  parameter  int WIDTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/sseq_prescaler.sv
module sseq_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sseq_engine.sv
module sseq_engine
  import sseq_pkg::*;
#(
  parameter int PC_W   = 6,
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic              early_i,
  input  logic              tick_i,
  input  instr_t            instr_i,
  input  logic              sdi_i,
  input  logic              host_hi_we_i,
  input  logic              host_lo_we_i,
  input  logic [HALF_W-1:0] host_wdata_i,
  output logic              busy_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   stop_pc_o,
  output logic              done_o,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o,
  output logic              sclk_o,
  output logic              cs_o,
  output logic              sdo_o
);
  logic              busy_q, sclk_q, cs_q, sdo_q;
  logic [PC_W-1:0]   pc_q, stop_pc_q;
  logic [CNT_W-1:0]  half_q;
  logic [HALF_W-1:0] hi_q, lo_q;

  logic              is_direct, is_shift, is_stop;
  logic              lead, upd_reg, last_half;
  logic [HALF_W-1:0] operand, shifted;

  assign is_direct = instr_i.op == OP_DIRECT;
  assign is_shift  = instr_i.op == OP_SHIFT;
  assign is_stop   = !is_direct && !is_shift;  // undefined opcodes terminate
  assign lead      = ~half_q[0];
  assign last_half = half_q == instr_i.half_cnt;
  assign operand   = instr_i.sel_hi ? hi_q : lo_q;
  assign shifted   = {operand[HALF_W-2:0], instr_i.drive_out ? 1'b0 : sdi_i};
  assign upd_reg   = is_shift && (instr_i.drive_out ? !lead : (lead == early_i));
  assign done_o    = tick_i && is_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      pc_q      <= '0;
      stop_pc_q <= '0;
      half_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      sdo_q     <= 1'b0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        pc_q   <= start_pc_i;
        half_q <= '0;
      end else if (tick_i) begin
        cs_q <= instr_i.cs_lvl;
        if (is_stop) begin
          sclk_q    <= instr_i.clk_lvl;
          busy_q    <= 1'b0;
          stop_pc_q <= pc_q;
        end else if (is_direct) begin
          sclk_q <= instr_i.clk_lvl;
          pc_q   <= pc_q + 1'b1;
        end else begin
          sclk_q <= lead ? ~instr_i.clk_lvl : instr_i.clk_lvl;
          if (instr_i.drive_out && lead) sdo_q <= operand[HALF_W-1];
          if (upd_reg) begin
            if (instr_i.sel_hi) hi_q <= shifted;
            else                lo_q <= shifted;
          end
          if (last_half) begin
            half_q <= '0;
            pc_q   <= pc_q + 1'b1;
          end else begin
            half_q <= half_q + 1'b1;
          end
        end
      end
      if (!busy_q && host_hi_we_i) hi_q <= host_wdata_i;
      if (!busy_q && host_lo_we_i) lo_q <= host_wdata_i;
    end
  end

  assign busy_o    = busy_q;
  assign pc_o      = pc_q;
  assign stop_pc_o = stop_pc_q;
  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign sclk_o    = sclk_q;
  assign cs_o      = cs_q;
  assign sdo_o     = sdo_q;
endmodule

// File: rtl/sseq_top.sv
module sseq_top
  import sseq_pkg::*;
#(
  parameter  int DEPTH  = 32,
  parameter  int PC_W   = 6,
  parameter  int HALF_W = 16,
  parameter  int DIV_W  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int AW     = IDX_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          sdi_i,
  output logic          sclk_o,
  output logic          cs_o,
  output logic          sdo_o,
  output logic          irq_o
);
  logic              ram_sel, reg_wr, ctrl_wr, start_req, start_go, start_rej;
  reg_idx_e          idx;
  logic [PC_W-1:0]   start_pc_q;
  logic              early_q, mem_en_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        ist_q, ien_q, ist_clr, ist_set;
  logic              busy, tick, done;
  logic [PC_W-1:0]   pc, stop_pc;
  logic [HALF_W-1:0] hi, lo;
  logic [31:0]       instr_word, host_ram_word;

  assign ram_sel   = reg_addr_i[AW-1];
  assign idx       = reg_idx_e'(reg_addr_i[2:0]);
  assign reg_wr    = reg_we_i && !ram_sel;
  assign ctrl_wr   = reg_wr && (idx == RG_CTRL);
  assign start_req = ctrl_wr && reg_wdata_i[CTRL_START_BIT];
  assign start_go  = start_req && !busy;
  assign start_rej = start_req && busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_pc_q <= '0;
      early_q    <= 1'b0;
      mem_en_q   <= 1'b0;
      div_q      <= '0;
      ien_q      <= '0;
    end else if (reg_wr) begin
      case (idx)
        RG_CTRL: if (!busy) begin
          start_pc_q <= reg_wdata_i[PC_W-1:0];
          early_q    <= reg_wdata_i[CTRL_EARLY_BIT];
        end
        RG_MEM:  mem_en_q <= reg_wdata_i[0];
        RG_DIV:  div_q    <= reg_wdata_i[DIV_W-1:0];
        RG_IEN:  ien_q    <= reg_wdata_i[1:0];
        default: ;
      endcase
    end
  end

  // status: a set wins over a same-cycle clear
  assign ist_clr = (reg_wr && idx == RG_IST) ? reg_wdata_i[1:0] : 2'b00;
  assign ist_set = {start_rej, done};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ist_q <= '0;
    else         ist_q <= (ist_q & ~ist_clr) | ist_set;
  end

  assign irq_o = |(ist_q & ien_q);

  sseq_iram #(.DEPTH(DEPTH), .WIDTH(INSTR_W)) u_iram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i && ram_sel && mem_en_q),
    .waddr_i   (reg_addr_i[IDX_W-1:0]),
    .wdata_i   (reg_wdata_i),
    .raddr_a_i (pc[IDX_W-1:0]),
    .rdata_a_o (instr_word),
    .raddr_b_i (reg_addr_i[IDX_W-1:0]),
    .rdata_b_o (host_ram_word)
  );

  sseq_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  sseq_engine #(.PC_W(PC_W), .HALF_W(HALF_W)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_go),
    .start_pc_i   (reg_wdata_i[PC_W-1:0]),
    .early_i      (early_q),
    .tick_i       (tick),
    .instr_i      (instr_t'(instr_word)),
    .sdi_i        (sdi_i),
    .host_hi_we_i (reg_wr && idx == RG_HI),
    .host_lo_we_i (reg_wr && idx == RG_LO),
    .host_wdata_i (reg_wdata_i[HALF_W-1:0]),
    .busy_o       (busy),
    .pc_o         (pc),
    .stop_pc_o    (stop_pc),
    .done_o       (done),
    .hi_o         (hi),
    .lo_o         (lo),
    .sclk_o       (sclk_o),
    .cs_o         (cs_o),
    .sdo_o        (sdo_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (ram_sel) begin
      reg_rdata_o = host_ram_word;
    end else begin
      case (idx)
        RG_CTRL: begin
          reg_rdata_o[PC_W-1:0]      = start_pc_q;
          reg_rdata_o[CTRL_BUSY_BIT]  = busy;
          reg_rdata_o[CTRL_EARLY_BIT] = early_q;
        end
        RG_MEM:  reg_rdata_o[0]          = mem_en_q;
        RG_HI:   reg_rdata_o[HALF_W-1:0] = hi;
        RG_LO:   reg_rdata_o[HALF_W-1:0] = lo;
        RG_STOP: reg_rdata_o[PC_W-1:0]   = stop_pc;
        RG_DIV:  reg_rdata_o[DIV_W-1:0]  = div_q;
        RG_IST:  reg_rdata_o[1:0]        = ist_q;
        RG_IEN:  reg_rdata_o[1:0]        = ien_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sseq_checker.sv
module sseq_checker #(
  parameter int PC_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy,
  input logic            tick,
  input logic            start_req,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] stop_pc,
  input logic [1:0]      ist,
  input logic            sclk,
  input logic            cs,
  input logic            sdo
);
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && !busy) |=> busy);

  a_r2_busy_start_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && busy) |=> ist[1]);

  a_r3_pins_move_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable({sclk, cs, sdo}));

  a_r9_stop_records_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (stop_pc == $past(pc)) && ist[0]);

  a_r5_idle_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_req) |=> $stable(pc));
endmodule

bind sseq_top sseq_checker #(.PC_W(PC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy      (busy),
  .tick      (tick),
  .start_req (start_req),
  .pc        (pc),
  .stop_pc   (stop_pc),
  .ist       (ist_q),
  .sclk      (sclk_o),
  .cs        (cs_o),
  .sdo       (sdo_o)
);

// File: tb/sseq_top_test.sv
`timescale 1ns/1ps
module sseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sdi, sdi_fix = 1'b0, sdi_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        sclk, cs, sdo, irq;
  int          checks = 0, errors = 0;
  logic        cmp_en = 1'b0;

  always #2 clk = ~clk;

  assign sdi = sdi_rand ? lfsr[0] : sdi_fix;
  always @(posedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

  sseq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sdi_i(sdi),
    .sclk_o(sclk), .cs_o(cs), .sdo_o(sdo), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_ram [32];
  logic        m_busy, m_early, m_memen, m_sclk, m_cs, m_sdo;
  logic [5:0]  m_pc, m_spc, m_stop, m_k;
  logic [7:0]  m_cnt, m_div;
  logic [15:0] m_hi, m_lo;
  logic [1:0]  m_st, m_en;
  logic        t_tick, t_lead, t_wr, t_done, t_rej;
  logic [31:0] t_ins;
  logic [15:0] t_val;
  logic [1:0]  t_clr;
  logic        n_busy, n_early, n_memen, n_sclk, n_cs, n_sdo;
  logic [5:0]  n_pc, n_spc, n_stop, n_k;
  logic [7:0]  n_cnt, n_div;
  logic [15:0] n_hi, n_lo;
  logic [1:0]  n_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_ram[i] = '0;
      m_busy = 0; m_early = 0; m_memen = 0; m_sclk = 0; m_cs = 1; m_sdo = 0;
      m_pc = 0; m_spc = 0; m_stop = 0; m_k = 0; m_cnt = 0; m_div = 0;
      m_hi = 0; m_lo = 0; m_st = 0; m_en = 0;
    end else begin
      n_busy = m_busy; n_early = m_early; n_memen = m_memen; n_sclk = m_sclk;
      n_cs = m_cs; n_sdo = m_sdo; n_pc = m_pc; n_spc = m_spc; n_stop = m_stop;
      n_k = m_k; n_div = m_div; n_hi = m_hi; n_lo = m_lo; n_en = m_en;
      t_done = 0; t_rej = 0; t_clr = 0; t_wr = 0;
      t_tick = m_busy && (m_cnt == m_div);
      t_ins  = m_ram[m_pc[4:0]];
      n_cnt  = (!m_busy || t_tick) ? 8'd0 : m_cnt + 8'd1;
      if (t_tick) begin
        n_cs = t_ins[26];
        if (t_ins[31:28] == 4'd2) begin
          t_lead = (m_k[0] == 1'b0);
          n_sclk = t_lead ? !t_ins[25] : t_ins[25];
          t_val  = t_ins[24] ? m_hi : m_lo;
          if (t_ins[27]) begin
            if (t_lead) n_sdo = t_val[15];
            else begin t_val = t_val << 1; t_wr = 1; end
          end else if (t_lead == m_early) begin
            t_val = {t_val[14:0], sdi}; t_wr = 1;
          end
          if (t_wr) begin if (t_ins[24]) n_hi = t_val; else n_lo = t_val; end
          if (m_k == t_ins[5:0]) begin n_k = 0; n_pc = m_pc + 6'd1; end
          else n_k = m_k + 6'd1;
        end else if (t_ins[31:28] == 4'd1) begin
          n_sclk = t_ins[25]; n_pc = m_pc + 6'd1;
        end else begin
          n_sclk = t_ins[25]; n_busy = 0; n_stop = m_pc; t_done = 1;
        end
      end
      if (we) begin
        if (addr[5]) begin
          if (m_memen) m_ram[addr[4:0]] = wdata;
        end else case (addr[2:0])
          3'd0: if (!m_busy) begin
            n_spc = wdata[5:0]; n_early = wdata[11];
            if (wdata[15]) begin n_busy = 1; n_pc = wdata[5:0]; n_k = 0; end
          end else if (wdata[15]) t_rej = 1;
          3'd1: n_memen = wdata[0];
          3'd2: if (!m_busy) n_hi = wdata[15:0];
          3'd3: if (!m_busy) n_lo = wdata[15:0];
          3'd5: n_div = wdata[7:0];
          3'd6: t_clr = wdata[1:0];
          3'd7: n_en = wdata[1:0];
          default: ;
        endcase
      end
      m_st = (m_st & ~t_clr) | {t_rej, t_done};
      m_busy = n_busy; m_early = n_early; m_memen = n_memen; m_sclk = n_sclk;
      m_cs = n_cs; m_sdo = n_sdo; m_pc = n_pc; m_spc = n_spc; m_stop = n_stop;
      m_k = n_k; m_cnt = n_cnt; m_div = n_div; m_hi = n_hi; m_lo = n_lo; m_en = n_en;
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a[5]) return m_ram[a[4:0]];
    case (a[2:0])
      3'd0: return {20'd0, m_early, m_busy, 4'd0, m_spc};
      3'd1: return {31'd0, m_memen};
      3'd2: return {16'd0, m_hi};
      3'd3: return {16'd0, m_lo};
      3'd4: return {26'd0, m_stop};
      3'd5: return {24'd0, m_div};
      3'd6: return {30'd0, m_st};
      default: return {30'd0, m_en};
    endcase
  endfunction

  function automatic string addr_tag(logic [5:0] a);
    if (a[5]) return "R1 ram";
    case (a[2:0])
      3'd0: return "R2 ctrl";
      3'd1: return "R1 memctl";
      3'd2: return "R7 hi";
      3'd3: return "R8 lo";
      3'd4: return "R9 stop";
      3'd5: return "R3 div";
      default: return "R10 irq regs";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_en) begin
    check("R6 sclk_o", {31'd0, sclk}, {31'd0, m_sclk});
    check("R5 cs_o",   {31'd0, cs},   {31'd0, m_cs});
    check("R7 sdo_o",  {31'd0, sdo},  {31'd0, m_sdo});
    check("R10 irq_o", {31'd0, irq},  {31'd0, |(m_st & m_en)});
    check(addr_tag(addr), rdata, m_read(addr));
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1; addr = a; #0.5; d = rdata;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (m_busy && guard < 5000) begin @(posedge clk); guard++; end
    #1;
  endtask

  function automatic logic [31:0] mk(int op, bit o, bit c, bit k, bit s, int n);
    return (op << 28) | (o << 27) | (c << 26) | (k << 25) | (s << 24) | (n & 6'h3f);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] prog [11];
    prog[0]  = mk(1, 1, 1, 0, 0, 0);
    prog[1]  = mk(3, 1, 1, 0, 0, 0);
    prog[2]  = mk(1, 1, 0, 0, 0, 0);
    prog[3]  = mk(2, 1, 0, 0, 1, 15);
    prog[4]  = mk(3, 1, 0, 0, 0, 0);
    prog[5]  = mk(2, 0, 0, 0, 0, 15);
    prog[6]  = mk(3, 1, 0, 0, 0, 0);
    prog[7]  = mk(2, 0, 0, 1, 1, 31);
    prog[8]  = mk(2, 0, 0, 1, 0, 31);
    prog[9]  = mk(3, 1, 0, 1, 0, 0);
    prog[10] = 32'hF600_0000;

    #7;
    // R12: reset state at the pins
    check("R12 cs_o reset",   {31'd0, cs},   32'd1);
    check("R12 sclk_o reset", {31'd0, sclk}, 32'd0);
    check("R12 sdo_o reset",  {31'd0, sdo},  32'd0);
    @(posedge clk); #1; rst_n = 1;
    rd(6'd0, d); check("R12 ctrl reset", d, 32'd0);
    rd(6'd4, d); check("R12 stop reset", d, 32'd0);
    cmp_en = 1;

    // R1: gated RAM writes
    wr(6'd52, 32'hDEAD_BEEF);
    rd(6'd52, d); check("R1 write while disabled", d, 32'd0);
    wr(6'd1, 32'd1);
    for (int i = 0; i < 11; i++) wr(6'd32 + 6'(i), prog[i]);
    wr(6'd52, 32'h1357_9BDF);
    wr(6'd1, 32'd0);
    wr(6'd53, 32'hFFFF_FFFF);
    rd(6'd52, d); check("R1 write while enabled", d, 32'h1357_9BDF);
    rd(6'd53, d); check("R1 second disabled write", d, 32'd0);
    rd(6'd35, d); check("R4 instruction stored", d, prog[3]);

    // R7, R11: drive-out 8 bits MSB first, host write during run ignored
    wr(6'd7, 32'd1);
    wr(6'd2, 32'h0000_A5C3);
    wr(6'd0, 32'h0000_8002);
    rd(6'd0, d); check("R2 busy after start", d & 32'h400, 32'h400);
    wr(6'd2, 32'h0000_1234);
    wait_idle();
    rd(6'd2, d); check("R7 R11 upper half after out", d, 32'h0000_C300);
    rd(6'd4, d); check("R9 stop address", d, 32'd4);
    check("R10 irq after done", {31'd0, irq}, 32'd1);
    wr(6'd6, 32'd1);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);

    // R8 early sampling, R3 slower steps, R2 start during run rejected
    wr(6'd5, 32'd2);
    wr(6'd3, 32'd0);
    sdi_fix = 1;
    wr(6'd0, 32'h0000_8805);
    wr(6'd0, 32'h0000_8000);
    wait_idle();
    rd(6'd3, d); check("R8 early capture", d, 32'h0000_00FF);
    rd(6'd4, d); check("R2 rejected start kept run", d, 32'd6);
    rd(6'd6, d); check("R2 reject flag", d, 32'd3);
    wr(6'd6, 32'd1);
    check("R10 bit1 masked", {31'd0, irq}, 32'd0);
    wr(6'd7, 32'd3);
    check("R10 bit1 enabled", {31'd0, irq}, 32'd1);
    wr(6'd6, 32'd3);

    // R8 normal sampling of a random stream, 32 bits across both halves
    sdi_rand = 1;
    wr(6'd5, 32'd1);
    wr(6'd0, 32'h0000_8007);
    wait_idle();
    rd(6'd4, d); check("R9 stop after 32-bit read", d, 32'd9);
    rd(6'd2, d); check("R8 upper half captured", d, m_read(6'd2));
    sdi_rand = 0;

    // R4 undefined opcode behaves as stop
    wr(6'd5, 32'd0);
    wr(6'd0, 32'h0000_800A);
    wait_idle();
    rd(6'd4, d); check("R4 undefined opcode stops", d, 32'd10);
    check("R4 cs field applied", {31'd0, cs}, 32'd1);

    // R5 direct then stop
    wr(6'd0, 32'h0000_8000);
    wait_idle();
    rd(6'd4, d); check("R5 direct advanced to stop", d, 32'd1);
    check("R5 cs_o high", {31'd0, cs}, 32'd1);
    check("R6 sclk_o idle", {31'd0, sclk}, 32'd0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule